// File: doc/BRIEF.md
# Sequential single-MAC FIR filter

This block is an 8-tap finite impulse response filter for 16-bit signed samples. Only one multiplier and one accumulator exist. They are reused over successive cycles for every tap. Each accepted sample is written into a small circular history store. The stored samples are then read back newest-first, one per cycle, and multiplied by 16-bit signed coefficients from a read-only table. The products are summed in a wide accumulator, and the total is moved to a held output register with a one-cycle valid pulse.

The read-only table holds four coefficient sets. The set is picked at run time by a 2-bit window select, which is captured when a sample is accepted. A producer offers a sample with `sample_valid`. The sample is taken in a cycle where `sample_ready` is high. `sample_ready` stays low while a pass is running, so samples offered during that time are held off.

Top module: `mac_fir8`

## Requirements
- R1: After reset `sample_ready` is 1, `out_valid` is 0 and `out_data` is 0. The sample history is all zeros.
- R2: For each accepted sample x[n], `out_data` equals the sum over k=0..7 of c[k]·x[n−k]. Here x[n] is the sample just accepted, x[n−k] is the sample accepted k passes earlier, and history before reset counts as zero. Tap 0 pairs with the newest sample.
- R3: Every product is a signed 16×16 two's-complement multiply. For example, a sample 0xFFFB (−5) meeting coefficient 2 contributes −10, which appears on the 35-bit output as 0x7FFFFFFF6.
- R4: `win_sel` selects the coefficient set. With 0, c[0]=1 and all other taps are 0. With 1, c[k]=k+1. With 2, c[k]=+4096 for even k and −4096 for odd k. With 3, every c[k]=−32768.
- R5: `win_sel` is sampled only on the accepting clock edge. Changing it during a pass does not change that pass's result.
- R6: A sample is accepted on a rising edge where `sample_valid` and `sample_ready` are both 1. `sample_ready` is 0 from the next cycle on. `out_valid` is 1 for exactly one cycle, starting after the 9th rising edge following acceptance. `sample_ready` returns to 1 in that same cycle.
- R7: `sample_valid` while `sample_ready` is 0 is ignored. That sample is neither stored nor used in any later result.
- R8: The output is 35 bits signed and does not overflow. Eight samples of −32768 with set 3 give +2^33 (0x200000000).
- R9: `out_data` changes only in cycles where `out_valid` is 1, and holds otherwise.
- R10: A sample offered in the `out_valid` cycle is accepted at once. Back-to-back passes produce the same results as spaced passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_valid | input | 1 | A sample is offered on `sample_in` |
| sample_in | input | 16 | Signed input sample |
| win_sel | input | 2 | Coefficient set select, captured at acceptance |
| sample_ready | output | 1 | Block is idle and will take a sample |
| out_valid | output | 1 | One-cycle pulse: `out_data` was just updated |
| out_data | output | 35 | Signed filter result, held between updates |

## Verification
Two things can coincide in one cycle: the result latch with its `out_valid` pulse, and the acceptance of the next sample. Acceptance also clears the accumulator and advances the history pointer. The bench provokes this by streaming samples back-to-back, raising `sample_valid` in the very cycle `out_valid` is high. It then judges each result against a convolution computed in the bench and checks that no pass leaks its partial sum into the next. A second overlap is tested by holding `sample_valid` high with a junk value, and by changing `win_sel`, throughout a running pass. The bench then checks that later results contain neither the junk sample nor the new set.

// File: rtl/mac_fir_pkg.sv
package mac_fir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_LATCH = 2'd2
  } pass_state_e;

endpackage

// File: rtl/sample_ptr.sv
module sample_ptr #(
  parameter int TAPS = 8,
  localparam int TAP_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [TAP_W-1:0] tap,
  output logic [TAP_W-1:0] waddr,
  output logic [TAP_W-1:0] raddr
);

  logic [TAP_W-1:0] wr_q, wr_d;
  logic [TAP_W:0]   rd_sum;

  always_comb begin
    wr_d = wr_q;
    if (advance) begin
      if (wr_q == TAP_W'(TAPS - 1)) wr_d = '0;
      else                          wr_d = wr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_q <= '0;
    else if (advance) wr_q <= wr_d;
  end

  // newest entry sits one below the write pointer; tap k steps further back
  always_comb begin
    rd_sum = {1'b0, wr_q} + (TAP_W+1)'(TAPS - 1) - {1'b0, tap};
    if (rd_sum >= (TAP_W+1)'(TAPS)) rd_sum = rd_sum - (TAP_W+1)'(TAPS);
    raddr = rd_sum[TAP_W-1:0];
  end

  assign waddr = wr_q;

endmodule

// File: rtl/sample_ram.sv
module sample_ram #(
  parameter int TAPS   = 8,
  parameter int DATA_W = 16,
  localparam int TAP_W = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic              rd,
  input  logic [TAP_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TAP_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem_q [TAPS];
  logic              wr_en;

  assign wr_en = cs & we;

  for (genvar i = 0; i < TAPS; i++) begin : g_word
    logic hit;
    assign hit = wr_en && (waddr == TAP_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[i] <= '0;
      else if (hit) mem_q[i] <= wdata;
    end
  end

  assign rdata = (cs & rd) ? mem_q[raddr] : '0;

endmodule

// File: rtl/coef_rom.sv
module coef_rom #(
  parameter int TAPS   = 8,
  parameter int COEF_W = 16,
  parameter int SEL_W  = 2,
  localparam int TAP_W = $clog2(TAPS),
  localparam int NBANK = 1 << SEL_W,
  localparam int DEPTH = NBANK * TAPS,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              cs,
  input  logic              rd,
  input  logic [SEL_W-1:0]  bank,
  input  logic [TAP_W-1:0]  tap,
  output logic [COEF_W-1:0] coef
);

  function automatic logic [COEF_W-1:0] coef_at(input int b, input int k);
    logic [COEF_W-1:0] mag;
    mag = COEF_W'(1) << (COEF_W - 4);
    case (b % 4)
      0:       coef_at = (k == 0) ? COEF_W'(1) : '0;
      1:       coef_at = COEF_W'(k + 1);
      2:       coef_at = (k % 2 == 1) ? (~mag + 1'b1) : mag;
      default: coef_at = {1'b1, {(COEF_W-1){1'b0}}};
    endcase
  endfunction

  logic [COEF_W-1:0] rom [DEPTH];
  logic [IDX_W-1:0]  idx;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
      assign rom[b*TAPS + k] = coef_at(b, k);
    end
  end

  assign idx  = IDX_W'(bank) * IDX_W'(TAPS) + IDX_W'(tap);
  assign coef = (cs & rd) ? rom[idx] : '0;

endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int TAPS   = 8,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int ACC_W  = PROD_W + $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_clr,
  input  logic              acc_en,
  input  logic              acc_lat,
  input  logic [DATA_W-1:0] sample,
  input  logic [COEF_W-1:0] coef,
  output logic [ACC_W-1:0]  result,
  output logic              res_valid
);

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc_q, acc_d;
  logic [ACC_W-1:0]         res_q, res_d;
  logic                     vld_q;

  assign prod     = $signed(sample) * $signed(coef);
  assign prod_ext = ACC_W'(prod);

  always_comb begin
    acc_d = acc_q;
    if (acc_clr)     acc_d = '0;
    else if (acc_en) acc_d = acc_q + prod_ext;
    res_d = acc_lat ? acc_q : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  acc_q <= '0;
    else if (acc_clr || acc_en)  acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       res_q <= '0;
    else if (acc_lat) res_q <= res_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= acc_lat;
  end

  assign result    = res_q;
  assign res_valid = vld_q;

endmodule

// File: rtl/mac_fir8.sv
module mac_fir8
  import mac_fir_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int SEL_W  = 2,
  localparam int TAP_W = $clog2(TAPS),
  localparam int ACC_W = DATA_W + COEF_W + $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [DATA_W-1:0] sample_in,
  input  logic [SEL_W-1:0]  win_sel,
  output logic              sample_ready,
  output logic              out_valid,
  output logic [ACC_W-1:0]  out_data
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // pass controller
  pass_state_e      state_q, state_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic [SEL_W-1:0] bank_q;
  logic             accept, running;
  logic             acc_clr, acc_en, acc_lat;

  assign accept  = sample_valid && (state_q == ST_IDLE);
  assign running = (state_q == ST_RUN);
  assign acc_clr = accept;
  assign acc_en  = running;
  assign acc_lat = (state_q == ST_LATCH);

  always_comb begin
    state_d = state_q;
    tap_d   = tap_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_RUN;
          tap_d   = '0;
        end
      end
      ST_RUN: begin
        if (tap_q == TAP_W'(TAPS - 1)) state_d = ST_LATCH;
        else                           tap_d   = tap_q + 1'b1;
      end
      ST_LATCH: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
    end else begin
      state_q <= state_d;
      tap_q   <= tap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  bank_q <= '0;
    else if (accept) bank_q <= win_sel;
  end

  // datapath
  logic [TAP_W-1:0]  waddr, raddr;
  logic [DATA_W-1:0] ram_rdata;
  logic [COEF_W-1:0] rom_coef;
  logic              ram_cs, ram_we, ram_rd;

  assign ram_cs = accept | running;
  assign ram_we = accept;
  assign ram_rd = running;

  sample_ptr #(.TAPS(TAPS)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .advance (ram_cs & ram_we),
    .tap     (tap_q),
    .waddr   (waddr),
    .raddr   (raddr)
  );

  sample_ram #(.TAPS(TAPS), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .rst_n (rst_int_n),
    .cs    (ram_cs),
    .we    (ram_we),
    .rd    (ram_rd),
    .waddr (waddr),
    .wdata (sample_in),
    .raddr (raddr),
    .rdata (ram_rdata)
  );

  coef_rom #(.TAPS(TAPS), .COEF_W(COEF_W), .SEL_W(SEL_W)) u_rom (
    .cs   (running),
    .rd   (running),
    .bank (bank_q),
    .tap  (tap_q),
    .coef (rom_coef)
  );

  mac_unit #(.TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W)) u_mac (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .acc_clr   (acc_clr),
    .acc_en    (acc_en),
    .acc_lat   (acc_lat),
    .sample    (ram_rdata),
    .coef      (rom_coef),
    .result    (out_data),
    .res_valid (out_valid)
  );

  assign sample_ready = (state_q == ST_IDLE);

endmodule

// File: rtl/mac_fir8_chk.sv
module mac_fir8_chk #(
  parameter int TAPS  = 8,
  parameter int ACC_W = 35,
  localparam int CNT_W = $clog2(TAPS + 1) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_valid,
  input logic             sample_ready,
  input logic             out_valid,
  input logic [ACC_W-1:0] out_data,
  input logic             acc_clr,
  input logic             acc_en,
  input logic             acc_lat
);

  logic [CNT_W-1:0] add_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       add_cnt <= '0;
    else if (acc_clr) add_cnt <= '0;
    else if (acc_en)  add_cnt <= add_cnt + 1'b1;
  end

  // R2: exactly TAPS products are summed before each latch
  a_r2_tap_count: assert property (@(posedge clk) disable iff (!rst_n)
    acc_lat |-> (add_cnt == CNT_W'(TAPS)));

  // R6: result pulse lasts one cycle
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6: ready returns together with the result pulse
  a_r6_ready_at_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> sample_ready);

  // R7: an accepted sample makes the block busy on the next cycle
  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && sample_ready) |=> !sample_ready);

  // R9: output moves only with its valid pulse
  a_r9_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_data) |-> out_valid);

endmodule

bind mac_fir8 mac_fir8_chk #(.TAPS(TAPS), .ACC_W(ACC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_int_n),
  .sample_valid (sample_valid),
  .sample_ready (sample_ready),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .acc_clr      (acc_clr),
  .acc_en       (acc_en),
  .acc_lat      (acc_lat)
);

// File: tb/mac_fir8_bench.sv
`timescale 1ns/1ps
module mac_fir8_bench;

  logic        clk;
  logic        rst_n;
  logic        sample_valid;
  logic [15:0] sample_in;
  logic [1:0]  win_sel;
  logic        sample_ready;
  logic        out_valid;
  logic [34:0] out_data;

  int checks;
  int errors;
  bit done;

  logic signed [15:0] hist [8];
  logic [34:0]        last_exp;

  mac_fir8 u_mac_fir8 (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_valid (sample_valid),
    .sample_in    (sample_in),
    .win_sel      (win_sel),
    .sample_ready (sample_ready),
    .out_valid    (out_valid),
    .out_data     (out_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic longint coef_ref(input logic [1:0] w, input int k);
    case (w)
      2'd0:    return (k == 0) ? 1 : 0;
      2'd1:    return k + 1;
      2'd2:    return (k % 2 == 1) ? -4096 : 4096;
      default: return -32768;
    endcase
  endfunction

  function automatic logic [34:0] conv_ref(input logic [1:0] w);
    longint s;
    s = 0;
    for (int k = 0; k < 8; k++) s += coef_ref(w, k) * longint'(hist[k]);
    return s[34:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one filter pass; called at a falling edge with the block idle
  task automatic send(input logic [15:0] d, input logic [1:0] w,
                      input bit chg_win, input logic [1:0] w2,
                      input bit junk, input string req);
    chk(sample_ready == 1'b1, req, "ready before offer", longint'(sample_ready), 1);
    sample_in    = d;
    win_sel      = w;
    sample_valid = 1'b1;
    for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
    hist[0]  = d;
    last_exp = conv_ref(w);
    @(posedge clk);
    @(negedge clk);
    chk(sample_ready == 1'b0, "R6", "ready low after accept", longint'(sample_ready), 0);
    if (junk) begin
      sample_valid = 1'b1;
      sample_in    = 16'h7777;
    end else begin
      sample_valid = 1'b0;
    end
    if (chg_win) win_sel = w2;
    repeat (8) @(negedge clk);
    chk(out_valid == 1'b0, "R6", "no early out_valid", longint'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R6", "out_valid after 9 edges", longint'(out_valid), 1);
    chk(sample_ready == 1'b1, "R6", "ready with out_valid", longint'(sample_ready), 1);
    chk(out_data == last_exp, req, "result", longint'(out_data), longint'(last_exp));
    sample_valid = 1'b0;
  endtask

  task automatic idle_hold(input string req);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6", "pulse one cycle", longint'(out_valid), 0);
    chk(out_data == last_exp, req, "output held", longint'(out_data), longint'(last_exp));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    sample_valid = 1'b0;
    sample_in = '0;
    win_sel = '0;
    for (int k = 0; k < 8; k++) hist[k] = '0;
    last_exp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sample_ready == 1'b1, "R1", "ready after reset", longint'(sample_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
    chk(out_data == '0, "R1", "out_data after reset", longint'(out_data), 0);
  endtask

  task automatic t_history_zero();
    // set 1 sums all taps: a zero history leaves only the new sample
    send(16'd3, 2'd1, 1'b0, 2'd0, 1'b0, "R1");
    idle_hold("R9");
  endtask

  task automatic t_ramp();
    // push the history clear first, then walk a unit sample through set 1
    for (int i = 0; i < 8; i++) begin
      send(16'd0, 2'd0, 1'b0, 2'd0, 1'b0, "R2");
      idle_hold("R9");
    end
    send(16'd1, 2'd1, 1'b0, 2'd0, 1'b0, "R2");
    idle_hold("R9");
    for (int i = 1; i < 9; i++) begin
      send(16'd0, 2'd1, 1'b0, 2'd0, 1'b0, "R2");
      chk(out_data == ((i < 8) ? 35'(i + 1) : 35'd0), "R2", "tap order",
          longint'(out_data), (i < 8) ? i + 1 : 0);
      idle_hold("R9");
    end
  endtask

  task automatic t_signed();
    send(16'hFFFB, 2'd1, 1'b0, 2'd0, 1'b0, "R3");
    idle_hold("R9");
    send(16'h0000, 2'd1, 1'b0, 2'd0, 1'b0, "R3");
    chk(out_data == 35'h7FFFFFFF6, "R3", "minus ten", longint'(out_data), 35'h7FFFFFFF6);
    idle_hold("R9");
  endtask

  task automatic t_banks();
    logic [15:0] vals [8] = '{16'd100, 16'hFF38, 16'd7, 16'h8001,
                              16'h7FFF, 16'd0, 16'hFFFF, 16'd1234};
    for (int i = 0; i < 8; i++) begin
      send(vals[i], 2'(i % 4), 1'b0, 2'd0, 1'b0, "R4");
      idle_hold("R9");
    end
    send(16'd55, 2'd2, 1'b0, 2'd0, 1'b0, "R4");
    idle_hold("R9");
    send(16'd66, 2'd0, 1'b0, 2'd0, 1'b0, "R4");
    chk(out_data == 35'd66, "R4", "set 0 passes newest", longint'(out_data), 66);
    idle_hold("R9");
  endtask

  task automatic t_full_scale();
    for (int i = 0; i < 8; i++) begin
      send(16'h8000, 2'd3, 1'b0, 2'd0, 1'b0, "R8");
      idle_hold("R9");
    end
    chk(out_data == 35'h200000000, "R8", "full-scale sum", longint'(out_data), 35'h200000000);
  endtask

  task automatic t_mid_window();
    send(16'd321, 2'd1, 1'b1, 2'd2, 1'b0, "R5");
    idle_hold("R9");
    send(16'hFE00, 2'd2, 1'b1, 2'd0, 1'b0, "R5");
    idle_hold("R9");
  endtask

  task automatic t_busy_ignore();
    send(16'd11, 2'd0, 1'b0, 2'd0, 1'b1, "R7");
    idle_hold("R9");
    // junk would show up as tap 1 of set 1 if it had been written
    send(16'd22, 2'd1, 1'b0, 2'd0, 1'b1, "R7");
    idle_hold("R9");
    send(16'd33, 2'd1, 1'b0, 2'd0, 1'b0, "R7");
    idle_hold("R9");
  endtask

  task automatic t_back_to_back();
    logic [15:0] vals [6] = '{16'd5, 16'hFFF0, 16'd900, 16'h4000, 16'hC000, 16'd17};
    for (int i = 0; i < 6; i++)
      send(vals[i], 2'(i % 4), 1'b0, 2'd0, 1'b0, "R10");
    idle_hold("R10");
  endtask

  initial begin
    checks = 0;
    errors = 0;
    done   = 1'b0;
    t_reset();
    t_history_zero();
    t_ramp();
    t_signed();
    t_banks();
    t_full_scale();
    t_mid_window();
    t_busy_ignore();
    t_back_to_back();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule